// File: doc/BRIEF.md
# Serial EEPROM Slave Front End

This block is the serial-interface side of a 512-byte serial EEPROM. A host drives a four-wire SPI bus (clock, active-low select, data in, data out) plus a pause input and a write-protect input. The block shifts in an 8-bit opcode, collects a 9-bit byte address whose top bit rides inside the opcode, and then either streams array bytes out or passes write bytes to a separate page-write engine. It also keeps the status register: write-enable latch, two block-protect bits, and a busy bit that the page-write engine supplies.

All bus pins are sampled by the chip clock `clk`. Serial clock edges are found with one sampling register, so the serial clock must run well below `clk`. The 512x8 array is a plain register memory. It is read here and written through a port owned by the page-write engine, which receives one `pw_valid` pulse per data byte and then a `pw_commit` or `pw_cancel` pulse when select rises.

Top module: `eeprom_spi_slave`

## Requirements
- R1: Opcode `0000_h011` starts a read at address {h, next byte}, where h is opcode bit 3. The byte at that address goes out on `so` MSB first, one bit per serial clock falling edge. The host samples each bit on the following rising edge.
- R2: In a read, each further byte comes from the next address, and address 0x1FF is followed by 0x000 for as long as clocks continue.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either takes effect only if select rises after exactly 8 bits of the transfer.
- R4: Opcode 0x05 returns the status byte {0000, BP1, BP0, WEL, WIP} (WIP in bit 0) and repeats it for every further byte. It is also served while `pw_busy` is high.
- R5: Opcode 0x01 followed by one byte loads BP1/BP0 from that byte's bits 3/2 and clears WEL. This happens only when select rises after exactly 16 bits, with WEL set and `wp_n` high at the opcode. Otherwise the status register is unchanged.
- R6: Opcode `0000_h010`, accepted only with WEL set and `wp_n` high, emits one `pw_valid` per received data byte. The address's low 4 bits increment and wrap inside the 16-byte page. When select rises at a byte boundary after at least one data byte, `pw_commit` pulses; otherwise `pw_cancel` pulses. A rejected write emits nothing.
- R7: While `hold_n` is low, serial clock edges are ignored, `so` holds and `so_oe` is low. After release the transfer continues from the same bit.
- R8: Any other opcode is ignored: `so_oe` stays low until select rises.
- R9: While `pw_busy` is high, every opcode except 0x05 is ignored. A read then never drives `so_oe`.
- R10: WEL clears on the cycle after `pw_busy` falls.
- R11: Select high drops `so_oe` and returns the bit counter to the opcode, so the next transfer decodes afresh.
- R12: After reset `so_oe` is low and the status byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that samples all bus pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low = high impedance) |
| pw_valid | output | 1 | One data byte for the page-write engine |
| pw_addr | output | 9 | Address of that byte |
| pw_data | output | 8 | The byte |
| pw_commit | output | 1 | Write sequence ended cleanly; program the page |
| pw_cancel | output | 1 | Write sequence ended mid-byte or empty; discard |
| pw_busy | input | 1 | Page-write engine is programming (WIP) |
| mem_we | input | 1 | Array write strobe from the page-write engine |
| mem_waddr | input | 9 | Array write address |
| mem_wdata | input | 8 | Array write data |

## Verification
A serial clock edge reaches the state one `clk` after it is sampled. So `so` changes one `clk` after the sampled falling edge, and `pw_valid` appears one `clk` after the eighth rising edge of a byte. `pw_commit`/`pw_cancel` and the write-enable and protect updates appear one `clk` after select is seen high, and WEL drops one `clk` after `pw_busy` falls. The bench holds each serial half period for four `clk` cycles and reads `so` at the end of the low half, just before it raises the clock. It counts the one-cycle engine pulses on falling `clk` edges, and takes status effects from a fresh status read after select has been high for eight cycles.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

    typedef enum logic [2:0] {
        PH_CMD,     // collecting opcode
        PH_ADDR,    // collecting low address byte
        PH_RDATA,   // streaming array bytes
        PH_WDATA,   // collecting write bytes
        PH_STAT,    // streaming status byte
        PH_WSR,     // collecting new status byte
        PH_DONE,    // complete; waits for select to rise
        PH_IGNORE   // discard until select rises
    } phase_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_READ, OP_WRITE, OP_WREN, OP_WRDI, OP_WRSR
    } op_e;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [2:0] OPC_RD_LO = 3'b011;
    localparam logic [2:0] OPC_WR_LO = 3'b010;

endpackage

// File: rtl/eeprom_spi_edges.sv
module eeprom_spi_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    typedef struct packed {
        logic sck;
        logic cs_n;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.sck  = sck;
        smp_d.cs_n = cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q.sck  <= 1'b0;
            smp_q.cs_n <= 1'b1;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign sck_rise = sck & ~smp_q.sck;
    assign sck_fall = ~sck & smp_q.sck;
    assign cs_rise  = cs_n & ~smp_q.cs_n;
endmodule

// File: rtl/eeprom_spi_array.sv
module eeprom_spi_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_spi_status.sv
module eeprom_spi_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       bp_we,
    input  logic [1:0] bp_wdata,
    output logic       wel,
    output logic [1:0] bp
);
    typedef struct packed {
        logic       wel;
        logic [1:0] bp;
        logic       busy;
    } sts_t;

    sts_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.busy = busy;
        if (set_wel)
            s_d.wel = 1'b1;
        else if (clr_wel || (s_q.busy && !busy))
            s_d.wel = 1'b0;
        if (bp_we)
            s_d.bp = bp_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wel = s_q.wel;
    assign bp  = s_q.bp;
endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave
    import eeprom_spi_pkg::*;
#(
    parameter int ADDR_W = 9,   // must equal DATA_W + 1: one address bit rides in the opcode
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    input  logic              wp_n,
    output logic              so,
    output logic              so_oe,
    output logic              pw_valid,
    output logic [ADDR_W-1:0] pw_addr,
    output logic [DATA_W-1:0] pw_data,
    output logic              pw_commit,
    output logic              pw_cancel,
    input  logic              pw_busy,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [DATA_W-1:0] mem_wdata
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e            phase;
        op_e               op;
        logic [CNT_W-1:0]  bits;
        logic [DATA_W-1:0] shreg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] out_sr;
        logic              so;
        logic              have_byte;
        logic              pw_valid;
        logic [ADDR_W-1:0] pw_addr;
        logic [DATA_W-1:0] pw_data;
        logic              pw_commit;
        logic              pw_cancel;
    } st_t;

    st_t st_d, st_q;

    logic              sck_rise, sck_fall, cs_rise;
    logic              set_wel, clr_wel, bp_we, wel;
    logic [1:0]        bp;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] status_byte;
    logic              wr_ok;

    eeprom_spi_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    eeprom_spi_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    eeprom_spi_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (pw_busy),
        .set_wel  (set_wel),
        .clr_wel  (clr_wel),
        .bp_we    (bp_we),
        .bp_wdata (st_q.shreg[3:2]),
        .wel      (wel),
        .bp       (bp)
    );

    assign shifted     = {st_q.shreg[DATA_W-2:0], si};
    assign status_byte = {{(DATA_W-4){1'b0}}, bp, wel, pw_busy};
    assign wr_ok       = wel && wp_n;
    // while the low address byte arrives, look ahead to the addressed cell
    assign rd_addr     = (st_q.phase == PH_ADDR) ? {st_q.addr[ADDR_W-1], shifted} : st_q.addr;

    always_comb begin
        st_d           = st_q;
        st_d.pw_valid  = 1'b0;
        st_d.pw_commit = 1'b0;
        st_d.pw_cancel = 1'b0;
        set_wel        = 1'b0;
        clr_wel        = 1'b0;
        bp_we          = 1'b0;

        if (cs_n) begin
            if (cs_rise) begin
                if (st_q.phase == PH_WDATA) begin
                    if (st_q.have_byte && st_q.bits == '0) st_d.pw_commit = 1'b1;
                    else                                   st_d.pw_cancel = 1'b1;
                end else if (st_q.phase == PH_DONE) begin
                    case (st_q.op)
                        OP_WREN: set_wel = 1'b1;
                        OP_WRDI: clr_wel = 1'b1;
                        OP_WRSR: begin bp_we = 1'b1; clr_wel = 1'b1; end
                        default: ;
                    endcase
                end
            end
            st_d.phase     = PH_CMD;
            st_d.op        = OP_NONE;
            st_d.bits      = '0;
            st_d.have_byte = 1'b0;
            st_d.out_sr    = '0;
        end else if (hold_n) begin
            if (sck_fall && (st_q.phase == PH_RDATA || st_q.phase == PH_STAT)) begin
                st_d.so     = st_q.out_sr[DATA_W-1];
                st_d.out_sr = st_q.out_sr << 1;
            end
            if (sck_rise) begin
                st_d.shreg = shifted;
                st_d.bits  = st_q.bits + 1'b1;
                if (st_q.phase == PH_DONE) begin
                    st_d.phase = PH_IGNORE;
                end else if (st_q.bits == LAST_BIT) begin
                    case (st_q.phase)
                        PH_CMD: begin
                            if (pw_busy && shifted != OPC_RDSR) begin
                                st_d.phase = PH_IGNORE;
                            end else if (shifted[7:4] == 4'h0 && shifted[2:0] == OPC_RD_LO) begin
                                st_d.op                = OP_READ;
                                st_d.addr[ADDR_W-1]    = shifted[3];
                                st_d.phase             = PH_ADDR;
                            end else if (shifted[7:4] == 4'h0 && shifted[2:0] == OPC_WR_LO) begin
                                st_d.op                = OP_WRITE;
                                st_d.addr[ADDR_W-1]    = shifted[3];
                                st_d.phase             = wr_ok ? PH_ADDR : PH_IGNORE;
                            end else if (shifted == OPC_WREN) begin
                                st_d.op    = OP_WREN;
                                st_d.phase = PH_DONE;
                            end else if (shifted == OPC_WRDI) begin
                                st_d.op    = OP_WRDI;
                                st_d.phase = PH_DONE;
                            end else if (shifted == OPC_RDSR) begin
                                st_d.phase  = PH_STAT;
                                st_d.out_sr = status_byte;
                            end else if (shifted == OPC_WRSR) begin
                                st_d.op    = OP_WRSR;
                                st_d.phase = wr_ok ? PH_WSR : PH_IGNORE;
                            end else begin
                                st_d.phase = PH_IGNORE;
                            end
                        end
                        PH_ADDR: begin
                            if (st_q.op == OP_READ) begin
                                st_d.phase  = PH_RDATA;
                                st_d.out_sr = rd_data;
                                st_d.addr   = rd_addr + 1'b1;
                            end else begin
                                st_d.phase  = PH_WDATA;
                                st_d.addr   = rd_addr;
                            end
                        end
                        PH_RDATA: begin
                            st_d.out_sr = rd_data;
                            st_d.addr   = st_q.addr + 1'b1;
                        end
                        PH_WDATA: begin
                            st_d.pw_valid  = 1'b1;
                            st_d.pw_addr   = st_q.addr;
                            st_d.pw_data   = shifted;
                            st_d.have_byte = 1'b1;
                            st_d.addr      = {st_q.addr[ADDR_W-1:PAGE_W],
                                              st_q.addr[PAGE_W-1:0] + 1'b1};
                        end
                        PH_STAT:  st_d.out_sr = status_byte;
                        PH_WSR:   st_d.phase  = PH_DONE;
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign so        = st_q.so;
    assign so_oe     = !cs_n && hold_n && (st_q.phase == PH_RDATA || st_q.phase == PH_STAT);
    assign pw_valid  = st_q.pw_valid;
    assign pw_addr   = st_q.pw_addr;
    assign pw_data   = st_q.pw_data;
    assign pw_commit = st_q.pw_commit;
    assign pw_cancel = st_q.pw_cancel;
endmodule

// File: rtl/eeprom_spi_slave_chk.sv
module eeprom_spi_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic hold_n,
    input logic so,
    input logic so_oe,
    input logic pw_valid,
    input logic pw_commit,
    input logic pw_cancel,
    input logic pw_busy,
    input logic wel
);
    // R6: a write sequence ends either committed or cancelled, never both
    a_r6_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pw_commit && pw_cancel));

    // R7: paused bus leaves the output undriven
    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |-> !so_oe);

    // R7: paused bus freezes the output bit
    a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |=> $stable(so));

    // R9: no new write bytes while the engine is programming
    a_r9_busy_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_busy && $past(pw_busy)) |-> !pw_valid);

    // R10: end of programming drops the write-enable latch
    a_r10_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pw_busy) |=> !wel);
endmodule

bind eeprom_spi_slave eeprom_spi_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_n    (hold_n),
    .so        (so),
    .so_oe     (so_oe),
    .pw_valid  (pw_valid),
    .pw_commit (pw_commit),
    .pw_cancel (pw_cancel),
    .pw_busy   (pw_busy),
    .wel       (wel)
);

// File: tb/eeprom_spi_slave_test.sv
`timescale 1ns/1ps
module eeprom_spi_slave_test;
    localparam int HALF = 4;
    localparam int NRD  = 4;
    // {start address, byte count}
    localparam logic [13:0] RD_VEC [NRD] = '{
        {9'h000, 5'd3}, {9'h1FE, 5'd4}, {9'h0FE, 5'd3}, {9'h123, 5'd2}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe, pw_valid, pw_commit, pw_cancel;
    logic [8:0] pw_addr;
    logic [7:0] pw_data;
    logic pw_busy = 1'b0, mem_we = 1'b0;
    logic [8:0] mem_waddr = '0;
    logic [7:0] mem_wdata = '0;

    int n_checks = 0, n_err = 0;
    int oe_cnt = 0, pwv_cnt = 0, commit_cnt = 0, cancel_cnt = 0;
    logic [8:0] cap_addr [32];
    logic [7:0] cap_data [32];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    eeprom_spi_slave uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .wp_n(wp_n), .so(so), .so_oe(so_oe), .pw_valid(pw_valid), .pw_addr(pw_addr),
        .pw_data(pw_data), .pw_commit(pw_commit), .pw_cancel(pw_cancel),
        .pw_busy(pw_busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    always @(negedge clk) begin
        if (so_oe) oe_cnt <= oe_cnt + 1;
        if (pw_valid) begin
            cap_addr[pwv_cnt % 32] <= pw_addr;
            cap_data[pwv_cnt % 32] <= pw_data;
            pwv_cnt <= pwv_cnt + 1;
        end
        if (pw_commit) commit_cnt <= commit_cnt + 1;
        if (pw_cancel) cancel_cnt <= cancel_cnt + 1;
    end

    function automatic logic [7:0] pat(input logic [8:0] a);
        return a[7:0] * 8'd13 + (a[8] ? 8'd91 : 8'd0) + 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0; tick(HALF);
    endtask

    task automatic cs_hi();
        sck = 1'b0; tick(HALF); cs_n = 1'b1; tick(2 * HALF);
    endtask

    task automatic xbit(input logic b, output logic o);
        sck = 1'b0; si = b; tick(HALF);
        o = so;
        sck = 1'b1; tick(HALF);
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] o);
        for (int i = 7; i >= 0; i--) begin
            logic t;
            xbit(b[i], t);
            o[i] = t;
        end
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_lo(); xbyte(8'h05, d); xbyte(8'h00, s); cs_hi();
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_lo(); xbyte(op, d); cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        cs_lo(); xbyte(8'h01, d); xbyte(v, d); cs_hi();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, s;
        logic [8:0] a;
        int base, oe0, pv0, cm0, cn0;
        logic [7:0] exp_page [16];

        tick(4);
        chk("R12 so_oe in reset", {31'b0, so_oe}, 0);
        rst_n = 1'b1;
        tick(2);
        // preload the array through the engine's write port
        for (int i = 0; i < 512; i++) begin
            mem_we = 1'b1; mem_waddr = 9'(i); mem_wdata = pat(9'(i)); tick(1);
        end
        mem_we = 1'b0; tick(2);
        chk("R12 so_oe after reset", {31'b0, so_oe}, 0);
        rdsr(s); chk("R12 status after reset", {24'b0, s}, 32'h00);

        // R1 R2: table-driven sequential reads
        for (int v = 0; v < NRD; v++) begin
            a = RD_VEC[v][13:5];
            cs_lo();
            xbyte({4'b0, a[8], 3'b011}, d);
            xbyte(a[7:0], d);
            for (int k = 0; k < int'(RD_VEC[v][4:0]); k++) begin
                xbyte(8'h00, d);
                chk(k == 0 ? "R1 read data" : "R2 sequential/wrap data", {24'b0, d}, {24'b0, pat(a + 9'(k))});
            end
            cs_hi();
        end

        // R3: opcode with extra bits does not set the latch
        cs_lo(); xbyte(8'h06, d); xbyte(8'h00, d); cs_hi();
        rdsr(s); chk("R3 latch needs exactly 8 bits", {24'b0, s}, 32'h00);
        cmd1(8'h06); rdsr(s); chk("R3 latch set", {24'b0, s}, 32'h02);
        cmd1(8'h04); rdsr(s); chk("R3 latch cleared", {24'b0, s}, 32'h00);

        // R5: status write gating
        wrsr(8'h0C); rdsr(s); chk("R5 no write without latch", {24'b0, s}, 32'h00);
        cmd1(8'h06); wp_n = 1'b0; wrsr(8'h0C); wp_n = 1'b1;
        rdsr(s); chk("R5 protected status write ignored", {24'b0, s}, 32'h02);
        wrsr(8'hFC); rdsr(s); chk("R5 protect bits loaded, latch cleared", {24'b0, s}, 32'h0C);

        // R6: write without latch is rejected
        pv0 = pwv_cnt; cn0 = cancel_cnt; cm0 = commit_cnt;
        cs_lo(); xbyte(8'h02, d); xbyte(8'h10, d); xbyte(8'h55, d); cs_hi();
        chk("R6 rejected write emits no bytes", pwv_cnt - pv0, 0);
        chk("R6 rejected write emits no end pulse", (cancel_cnt - cn0) + (commit_cnt - cm0), 0);

        // R6: partial byte cancels
        cmd1(8'h06);
        pv0 = pwv_cnt; cn0 = cancel_cnt; cm0 = commit_cnt;
        cs_lo(); xbyte(8'h02, d); xbyte(8'h10, d); xbyte(8'h55, d);
        for (int i = 0; i < 3; i++) begin logic t; xbit(1'b1, t); end
        cs_hi();
        chk("R6 one byte before cancel", pwv_cnt - pv0, 1);
        chk("R6 cancel pulse", cancel_cnt - cn0, 1);
        chk("R6 no commit on cancel", commit_cnt - cm0, 0);

        // R6: page write with wrap, address bit 8 in opcode
        base = pwv_cnt; cm0 = commit_cnt;
        cs_lo(); xbyte(8'h0A, d); xbyte(8'hFD, d);
        for (int k = 0; k < 18; k++) xbyte(8'hC0 + 8'(k), d);
        cs_hi();
        chk("R6 byte count", pwv_cnt - base, 18);
        chk("R6 commit pulse", commit_cnt - cm0, 1);
        for (int k = 0; k < 18; k++) begin
            chk("R6 page-wrapped address", {23'b0, cap_addr[(base + k) % 32]},
                {23'b0, 9'h1F0 | 9'((13 + k) % 16)});
            exp_page[(13 + k) % 16] = 8'hC0 + 8'(k);
        end

        // engine model: programming cycle
        pw_busy = 1'b1; tick(2);
        for (int k = 0; k < 18; k++) begin
            mem_we = 1'b1; mem_waddr = cap_addr[(base + k) % 32];
            mem_wdata = cap_data[(base + k) % 32]; tick(1);
        end
        mem_we = 1'b0;
        rdsr(s); chk("R4 status while busy", {24'b0, s}, 32'h0F);
        oe0 = oe_cnt;
        cs_lo(); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h00, d); cs_hi();
        chk("R9 read ignored while busy", oe_cnt - oe0, 0);
        cmd1(8'h04); // ignored: latch must survive until busy falls
        rdsr(s); chk("R9 latch clear ignored while busy", {24'b0, s}, 32'h0F);
        pw_busy = 1'b0; tick(2);
        rdsr(s); chk("R10 latch dropped after programming", {24'b0, s}, 32'h0C);
        cs_lo(); xbyte(8'h0B, d); xbyte(8'hF0, d);
        for (int k = 0; k < 16; k++) begin
            xbyte(8'h00, d);
            chk("R6 programmed page content", {24'b0, d}, {24'b0, exp_page[k]});
        end
        cs_hi();

        // R4: status repeats
        cs_lo(); xbyte(8'h05, d); xbyte(8'h00, s); xbyte(8'h00, d); cs_hi();
        chk("R4 status repeated", {24'b0, d}, {24'b0, s});

        // R8: unknown opcode
        oe0 = oe_cnt;
        cs_lo(); xbyte(8'hA5, d); xbyte(8'hFF, d); cs_hi();
        chk("R8 unknown opcode keeps output off", oe_cnt - oe0, 0);

        // R7: pause in the middle of a data byte
        cs_lo(); xbyte(8'h03, d); xbyte(8'h40, d);
        for (int i = 7; i >= 4; i--) begin logic t; xbit(1'b0, t); d[i] = t; end
        sck = 1'b0; tick(HALF);
        hold_n = 1'b0; tick(2);
        chk("R7 output off while paused", {31'b0, so_oe}, 0);
        sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        hold_n = 1'b1; tick(HALF);
        for (int i = 3; i >= 0; i--) begin logic t; xbit(1'b0, t); d[i] = t; end
        chk("R7 byte intact across pause", {24'b0, d}, {24'b0, pat(9'h040)});
        xbyte(8'h00, d);
        chk("R7 sequence continues after pause", {24'b0, d}, {24'b0, pat(9'h041)});
        cs_hi();

        // R11: select rise mid-read, then a fresh transfer decodes
        cs_lo(); xbyte(8'h0B, d); xbyte(8'h00, d);
        for (int i = 0; i < 3; i++) begin logic t; xbit(1'b0, t); end
        cs_hi();
        chk("R11 output off with select high", {31'b0, so_oe}, 0);
        cs_lo(); xbyte(8'h0B, d); xbyte(8'h01, d); xbyte(8'h00, d); cs_hi();
        chk("R11 fresh read after abort", {24'b0, d}, {24'b0, pat(9'h101)});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule